// File: doc/BRIEF.md
# Transmit Checksum Offload Inserter

This block sits on the transmit path of an Ethernet MAC. Software sends a frame as five 32-bit control words followed by the frame bytes. The control words decide whether a 16-bit ones'-complement checksum is patched into the frame, where the sum begins, which seed is added, and where the result goes. The bytes are summed while the frame arrives and are kept in a local buffer. The frame is released on the output only after the whole frame is in and the checksum is known, with the result bytes substituted at the chosen offset.

The block also applies two gates. The first is a transmit enable. The second is the size rule that removes frames slightly over standard length when neither jumbo nor VLAN handling is on. A frame that is removed is consumed and dropped in silence. Each frame that is sent completely raises a one-cycle completion pulse.

All three streams use valid/ready. A beat moves on a clock edge where both signals are high. While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold their values. The block handles one frame at a time, so `ctl_ready` and `in_ready` stay low until the current frame has been sent or dropped. Frames longer than the buffer depth are cut to the buffer depth.

Top module: `txcs_inserter`

## Requirements
- R1: Each frame starts with exactly five control words on the control stream. `ctl_ready` is high only while these words are being collected, and `in_ready` stays low until the fifth word is taken. Words 3 and 4 have no effect on the output.
- R2: When bit 0 of control word 0 is 0, the frame comes out byte for byte as it went in.
- R3: When bit 0 of control word 0 is 1, a checksum is computed as follows. The bytes from offset word1[31:16] up to the end of the frame are taken in pairs, counted from that start offset. Each pair is read as a big-endian 16-bit word, and a lone final byte is the high half with a low half of zero. The seed word2[15:0] is added. The 32-bit total is folded to 16 bits with end-around carry and then inverted. If the start offset is at or past the frame end, only the seed is summed.
- R4: The checksum high byte replaces the frame byte at offset word1[15:0], and the low byte replaces the byte at that offset plus 1. A result byte whose position is at or past the frame end is not emitted, so the frame length never changes.
- R5: If `tx_en` is low in the cycle after the last input byte is accepted, the frame produces no output beat and no `tx_done`. The block then accepts the next frame.
- R6: When `jumbo_en` and `vlan_en` are both 0, frames of 1519 to 1522 bytes are dropped as in R5. Frames of 1518 and 1523 bytes are sent. If either enable is 1, frames of 1519 to 1522 bytes are sent.
- R7: Output begins only after the whole frame has been accepted. `out_last` marks the final byte, and the output length equals the input length. While stalled, `out_data` and `out_last` hold steady.
- R8: `tx_done` is a one-cycle pulse in the cycle after the last output handshake of a sent frame.
- R9: Only one of collecting control words, taking frame bytes and sending output is active at any time.
- R10: After reset, `ctl_ready` is 1, and `in_ready`, `out_valid` and `tx_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_en | input | 1 | Transmit enable; when low, frames are dropped |
| jumbo_en | input | 1 | Allow frames longer than standard length |
| vlan_en | input | 1 | Allow frames up to 4 bytes over standard length |
| ctl_valid | input | 1 | Control word valid |
| ctl_ready | output | 1 | Control word accepted |
| ctl_data | input | 32 | Control word |
| in_valid | input | 1 | Frame byte valid |
| in_ready | output | 1 | Frame byte accepted |
| in_data | input | 8 | Frame byte |
| in_last | input | 1 | Final byte of the frame |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream accepts output byte |
| out_data | output | 8 | Output byte, checksum patched in |
| out_last | output | 1 | Final output byte |
| tx_done | output | 1 | Pulse after a frame has been fully sent |

## Verification
Two events can land on the same output beat. The first is the substitution of a checksum byte. The second is either the final beat of the frame or a back-pressure stall. The bench sweeps the insert offset across the frame end: at length-2, length-1 and length. It does this for several frame lengths and start offsets, and it drops `out_ready` on a repeating pattern. For each case, the bench compares every byte against a checksum computed with plain integer arithmetic, and it checks that the beat marked last is the byte at position length-1, even when a result byte falls on it or would fall just past it.

// File: rtl/txcs_pkg.sv
package txcs_pkg;

  localparam int unsigned OFF_W     = 16;
  localparam int unsigned CTL_WORDS = 5;

  typedef enum logic [1:0] {
    ST_CTL,
    ST_FILL,
    ST_FIN,
    ST_SEND
  } txcs_state_e;

  typedef struct packed {
    logic             ins_en;
    logic [OFF_W-1:0] start_off;
    logic [OFF_W-1:0] ins_off;
    logic [15:0]      seed;
  } txcs_ctl_t;

endpackage

// File: rtl/txcs_ctl_capture.sv
module txcs_ctl_capture
  import txcs_pkg::*;
#(
  parameter int unsigned WORDS = CTL_WORDS
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        take,
  input  logic [31:0] word,
  output txcs_ctl_t   ctl,
  output logic        done
);
  localparam int unsigned IW = $clog2(WORDS);
  localparam logic [IW-1:0] LAST_IDX = IW'(WORDS - 1);

  logic [IW-1:0] idx;

  assign done = take && (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx <= '0;
      ctl <= '0;
    end else if (take) begin
      idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
      case (idx)
        IW'(0): ctl.ins_en <= word[0];
        IW'(1): begin
          ctl.start_off <= word[31:16];
          ctl.ins_off   <= word[15:0];
        end
        IW'(2): ctl.seed <= word[15:0];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/txcs_sum_acc.sv
module txcs_sum_acc
  import txcs_pkg::*;
#(
  parameter int unsigned ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             add_en,
  input  logic [7:0]       byte_in,
  input  logic [OFF_W-1:0] pos,
  input  logic [OFF_W-1:0] start_off,
  input  logic [15:0]      seed,
  output logic [15:0]      csum
);
  logic [ACC_W-1:0] acc;
  logic [ACC_W-1:0] term;
  logic             in_range;
  logic             hi_half;
  logic [ACC_W-1:0] total;
  logic [16:0]      fold1;
  logic [15:0]      fold2;

  assign in_range = (pos >= start_off);
  assign hi_half  = (pos[0] == start_off[0]);
  assign term     = hi_half ? ACC_W'({byte_in, 8'h00}) : ACC_W'(byte_in);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) acc <= '0;
    else if (add_en && in_range) acc <= acc + term;
  end

  always_comb begin
    total = acc + ACC_W'(seed);
    fold1 = {1'b0, total[15:0]} + {1'b0, total[31:16]};
    fold2 = fold1[15:0] + {15'b0, fold1[16]};
    csum  = ~fold2;
  end
endmodule

// File: rtl/txcs_frame_buf.sv
module txcs_frame_buf #(
  parameter int unsigned DEPTH = 2048,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/txcs_inserter.sv
module txcs_inserter
  import txcs_pkg::*;
#(
  parameter int unsigned BUF_DEPTH   = 2048,
  parameter int unsigned MAX_STD_LEN = 1518,
  parameter int unsigned TAG_BYTES   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tx_en,
  input  logic        jumbo_en,
  input  logic        vlan_en,
  input  logic        ctl_valid,
  output logic        ctl_ready,
  input  logic [31:0] ctl_data,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [7:0]  in_data,
  input  logic        in_last,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [7:0]  out_data,
  output logic        out_last,
  output logic        tx_done
);
  localparam int unsigned AW = $clog2(BUF_DEPTH);
  localparam logic [OFF_W-1:0] CAP     = OFF_W'(BUF_DEPTH);
  localparam logic [OFF_W-1:0] STD_MAX = OFF_W'(MAX_STD_LEN);
  localparam logic [OFF_W-1:0] TAG_MAX = OFF_W'(MAX_STD_LEN + TAG_BYTES);

  txcs_state_e      st;
  txcs_ctl_t        ctl;
  logic             ctl_done;
  logic [OFF_W-1:0] wr_cnt;
  logic [OFF_W-1:0] rd_cnt;
  logic [OFF_W-1:0] len_q;
  logic [OFF_W-1:0] stored_len;
  logic [15:0]      sum_now;
  logic [15:0]      csum_q;
  logic             in_take;
  logic             out_take;
  logic             buf_we;
  logic [7:0]       buf_rdata;
  logic             oversize_tag;
  logic             drop;
  logic             patch_hi;
  logic             patch_lo;
  logic             done_q;

  assign ctl_ready = (st == ST_CTL);
  assign in_ready  = (st == ST_FILL);
  assign out_valid = (st == ST_SEND);
  assign in_take   = in_valid && in_ready;
  assign out_take  = out_valid && out_ready;
  assign buf_we    = in_take && (wr_cnt < CAP);
  assign stored_len = (wr_cnt > CAP) ? CAP : wr_cnt;

  txcs_ctl_capture #(.WORDS(CTL_WORDS)) u_ctl (
    .clk   (clk),
    .rst_n (rst_n),
    .take  (ctl_valid && ctl_ready),
    .word  (ctl_data),
    .ctl   (ctl),
    .done  (ctl_done)
  );

  txcs_sum_acc #(.ACC_W(32)) u_sum (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (ctl_done),
    .add_en    (buf_we),
    .byte_in   (in_data),
    .pos       (wr_cnt),
    .start_off (ctl.start_off),
    .seed      (ctl.seed),
    .csum      (sum_now)
  );

  txcs_frame_buf #(.DEPTH(BUF_DEPTH), .AW(AW)) u_buf (
    .clk   (clk),
    .we    (buf_we),
    .waddr (wr_cnt[AW-1:0]),
    .wdata (in_data),
    .raddr (rd_cnt[AW-1:0]),
    .rdata (buf_rdata)
  );

  assign oversize_tag = !jumbo_en && !vlan_en &&
                        (stored_len > STD_MAX) && (stored_len <= TAG_MAX);
  assign drop = !tx_en || oversize_tag;

  assign patch_hi = ctl.ins_en && (rd_cnt == ctl.ins_off);
  assign patch_lo = ctl.ins_en &&
                    ({1'b0, rd_cnt} == ({1'b0, ctl.ins_off} + 17'd1));

  always_comb begin
    out_data = buf_rdata;
    if (patch_hi)      out_data = csum_q[15:8];
    else if (patch_lo) out_data = csum_q[7:0];
  end

  assign out_last = (rd_cnt == len_q - 1'b1);
  assign tx_done  = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= ST_CTL;
      wr_cnt <= '0;
      rd_cnt <= '0;
      len_q  <= '0;
      csum_q <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= out_take && out_last;
      case (st)
        ST_CTL: begin
          if (ctl_done) begin
            wr_cnt <= '0;
            st     <= ST_FILL;
          end
        end
        ST_FILL: begin
          if (in_take) begin
            wr_cnt <= wr_cnt + 1'b1;
            if (in_last) st <= ST_FIN;
          end
        end
        ST_FIN: begin
          len_q  <= stored_len;
          csum_q <= sum_now;
          rd_cnt <= '0;
          st     <= drop ? ST_CTL : ST_SEND;
        end
        ST_SEND: begin
          if (out_take) begin
            rd_cnt <= rd_cnt + 1'b1;
            if (out_last) st <= ST_CTL;
          end
        end
        default: st <= ST_CTL;
      endcase
    end
  end
endmodule

// File: rtl/txcs_inserter_chk.sv
module txcs_inserter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_ready,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_last,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       tx_done
);
  // R7: a stalled output beat keeps its contents
  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R8: completion is one cycle wide
  a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R8: completion follows the final output handshake
  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |-> $past(out_valid && out_ready && out_last));

  // R9: phases never overlap
  a_r9_phase_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_ready, in_ready, out_valid}));

  // R7: no output and no new input in the cycle after the last byte is taken
  a_r7_gap_after_fill: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && in_last |=> !in_ready && !ctl_ready && !out_valid);
endmodule

bind txcs_inserter txcs_inserter_chk u_chk (.*);

// File: tb/txcs_inserter_bench.sv
module txcs_inserter_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, tx_en, jumbo_en, vlan_en;
  logic        ctl_valid, ctl_ready;
  logic [31:0] ctl_data;
  logic        in_valid, in_ready, in_last;
  logic [7:0]  in_data;
  logic        out_valid, out_ready, out_last;
  logic [7:0]  out_data;
  logic        tx_done;

  txcs_inserter u_txcs_inserter (.*);

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [7:0] frame [0:2047];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 190000) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [15:0] model_csum(input int len, input int st, input int seed);
    logic [31:0] s;
    s = 0;
    for (int i = st; i < len; i++) begin
      if (((i - st) % 2) == 0) s += {16'h0, frame[i], 8'h00};
      else s += {24'h0, frame[i]};
    end
    s += seed[15:0];
    while ((s >> 16) != 0) s = (s & 32'hFFFF) + (s >> 16);
    return ~s[15:0];
  endfunction

  task automatic put_ctl(input logic [31:0] w);
    ctl_valid = 1'b1;
    ctl_data  = w;
    while (!ctl_ready) @(negedge clk);
    @(negedge clk);
    ctl_valid = 1'b0;
  endtask

  task automatic put_frame(input int len);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = frame[i];
      in_last  = (i == len - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0;
    in_last  = 1'b0;
  endtask

  task automatic fill_frame(input int len, input int k, input bit all_ff);
    for (int i = 0; i < len; i++)
      frame[i] = all_ff ? 8'hFF : 8'((i * 37 + k * 11 + 5) & 255);
  endtask

  task automatic run_frame(input int len, input bit en, input int st, input int wo,
                           input int seed, input int bp, input bit sent, input string req);
    logic [15:0] cs;
    logic [7:0]  exp;
    logic [7:0]  got [0:2047];
    int          n, cyc, bad_at;
    bit          last_seen, prev_stall, stall_bad;
    logic [7:0]  prev_data;
    cs = model_csum(len, st, seed);
    put_ctl({31'h1B2C3D4E, en});
    put_ctl({st[15:0], wo[15:0]});
    put_ctl({16'hA5A5, seed[15:0]});
    put_ctl(32'hFFFF_FFFE);   // word 3, no effect (R1)
    put_ctl(32'h0F0F_0001);   // word 4, no effect (R1)
    put_frame(len);
    if (!sent) begin
      bad_at = 0;
      for (int c = 0; c < 8; c++) begin
        if (out_valid || tx_done) bad_at = 1;
        @(negedge clk);
      end
      chk(bad_at == 0, req, "dropped frame produced output", bad_at, 0);
      chk(ctl_ready == 1'b1, req, "ready for next frame after drop", ctl_ready, 1);
      return;
    end
    n = 0; cyc = 0; last_seen = 0; prev_stall = 0; stall_bad = 0; prev_data = 0;
    while (!last_seen) begin
      out_ready = (bp == 0) ? 1'b1 : ((cyc % (bp + 1)) != 0);
      if (prev_stall && out_valid && out_data != prev_data) stall_bad = 1;
      if (out_valid && out_ready) begin
        got[n] = out_data;
        n++;
        last_seen = out_last;
      end
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      @(negedge clk);
      cyc++;
    end
    out_ready = 1'b0;
    chk(tx_done == 1'b1, "R8", "tx_done after last beat", tx_done, 1);
    @(negedge clk);
    chk(tx_done == 1'b0, "R8", "tx_done one cycle", tx_done, 0);
    chk(!stall_bad, "R7", "data held while stalled", stall_bad, 0);
    chk(n == len, "R7", "output length", n, len);
    bad_at = -1;
    for (int i = 0; i < len && i < n; i++) begin
      exp = frame[i];
      if (en && i == wo) exp = cs[15:8];
      if (en && i == wo + 1) exp = cs[7:0];
      if (got[i] != exp && bad_at < 0) begin
        bad_at = i;
        chk(0, req, $sformatf("byte %0d len %0d st %0d wo %0d", i, len, st, wo),
            got[i], exp);
      end
    end
    if (bad_at < 0) chk(1, req, "frame bytes", 0, 0);
  endtask

  initial begin
    int lens [5];
    int l, s, w, sv;
    int starts [5];
    int wos [4];
    lens = '{1, 2, 3, 8, 21};
    rst_n = 0; tx_en = 1; jumbo_en = 0; vlan_en = 0;
    ctl_valid = 0; ctl_data = 0; in_valid = 0; in_data = 0; in_last = 0; out_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10 reset state
    chk(ctl_ready == 1 && in_ready == 0 && out_valid == 0 && tx_done == 0, "R10",
        "reset outputs", {ctl_ready, in_ready, out_valid, tx_done}, 4'b1000);

    // R1: after two words, still collecting, no data accepted
    put_ctl(32'h1); put_ctl(32'h0000_0002);
    chk(ctl_ready == 1 && in_ready == 0, "R1", "collecting control words",
        {ctl_ready, in_ready}, 2'b10);
    put_ctl(32'h0); put_ctl(32'h0); put_ctl(32'h0);
    chk(ctl_ready == 0 && in_ready == 1, "R1", "data phase after five words",
        {ctl_ready, in_ready}, 2'b01);
    fill_frame(4, 9, 0);
    put_frame(4);
    out_ready = 1;
    while (!tx_done) @(negedge clk);
    out_ready = 0;
    @(negedge clk);

    // R3/R4 sweep over length, start offset and insert offset
    for (int li = 0; li < 5; li++) begin
      l = lens[li];
      starts = '{0, 1, l - 1, l, l + 3};
      wos = '{0, (l >= 2) ? l - 2 : 0, l - 1, l};
      for (int si = 0; si < 5; si++) begin
        for (int wi = 0; wi < 4; wi++) begin
          s = starts[si]; w = wos[wi];
          sv = (li * 7919 + si * 131 + wi * 17 + ((si + wi) % 2) * 16'hFF00) & 16'hFFFF;
          fill_frame(l, li * 20 + si * 4 + wi, ((si + wi) % 3) == 0);
          run_frame(l, 1'b1, s, w, sv, (si + wi) % 3, 1'b1, "R3_R4");
        end
      end
    end

    // R2: insertion disabled, bytes unchanged
    fill_frame(21, 3, 0);
    run_frame(21, 1'b0, 0, 4, 16'h1234, 1, 1'b1, "R2");
    fill_frame(9, 4, 1);
    run_frame(9, 1'b0, 2, 8, 16'hFFFF, 0, 1'b1, "R2");

    // R5: transmit disabled drops, then recovers
    tx_en = 0;
    fill_frame(30, 5, 0);
    run_frame(30, 1'b1, 14, 20, 16'h0, 0, 1'b0, "R5");
    tx_en = 1;
    run_frame(30, 1'b1, 14, 20, 16'h0, 0, 1'b1, "R5");

    // R6: size rule
    fill_frame(1523, 6, 0);
    run_frame(1518, 1'b1, 14, 40, 16'h77, 0, 1'b1, "R6");
    run_frame(1519, 1'b1, 14, 40, 16'h77, 0, 1'b0, "R6");
    run_frame(1522, 1'b1, 14, 40, 16'h77, 0, 1'b0, "R6");
    run_frame(1523, 1'b1, 14, 40, 16'h77, 0, 1'b1, "R6");
    jumbo_en = 1;
    run_frame(1520, 1'b1, 14, 40, 16'h77, 0, 1'b1, "R6");
    jumbo_en = 0; vlan_en = 1;
    run_frame(1521, 1'b1, 14, 1519, 16'h77, 1, 1'b1, "R6");
    vlan_en = 0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule